// File: doc/BRIEF.md
# Pairwise Arbiter XOR Response Compressor

This block folds the race outcomes of a bank of delay chains into a short response word. Each pair of chains is compared twice: once on their upper lines and once on their lower lines. The arbiters that make these comparisons lie outside the block, and their one-bit outcomes arrive together as a single input vector. The block walks through that vector one outcome per clock, in a fixed pair order. It XORs consecutive runs of outcomes into successive bits of the response.

A one-cycle start pulse captures the outcome vector and begins the walk. While the walk runs, the block ignores further start pulses. When the last outcome has been folded, the block raises a one-cycle completion pulse. The response then stays unchanged until the next accepted start. The number of chains `K` and the response width `M` are parameters. The run length of each group is derived from them.

Top module: `pairwise_xor_compressor`

## Requirements
- R1: After reset, `resp_o` is all zeros and both `busy_o` and `done_o` are low.
- R2: A `start_i` high at a clock edge while `busy_o` is low captures `pair_dec_i`. It clears `resp_o` to zero and drives `busy_o` high from the next cycle.
- R3: `pair_dec_i` carries P = K(K-1)/2 upper-line outcomes in bits 0..P-1 and P lower-line outcomes in bits P..2P-1. Within each half, pairs (a,b) with a<b are packed with a ascending and then b ascending. Chain numbering starts at 0. The block folds exactly one outcome per clock in ascending bit order: every upper-line pair before any lower-line pair.
- R4: The group length is G = ceil(K(K-1)/M). Response bit r equals the XOR of captured outcomes with bit positions r*G through r*G+G-1.
- R5: If the final group holds fewer than G outcomes, its response bit is the XOR of only those outcomes. Response bits that no group reaches stay 0.
- R6: `done_o` is high for exactly one cycle. It rises K(K-1) cycles after the cycle in which the start was accepted, counting edges from the capturing edge.
- R7: `resp_o` keeps its final value, whatever `pair_dec_i` does, until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The walk, the completion time and the response follow the first captured vector.
- R9: `busy_o` stays high from the cycle after the capturing edge until the cycle in which `done_o` is high, and it is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture outcome vector and begin folding |
| pair_dec_i | input | K(K-1) | Pairwise race outcomes, layout per R3 |
| busy_o | output | 1 | Folding in progress |
| done_o | output | 1 | One-cycle completion pulse |
| resp_o | output | M | Folded response word |

## Verification
Three instances run side by side: an exact split (K=5, M=4), a short final group (K=5, M=3) and an unreached top bit (K=4, M=5). Single-bit vectors at the first, last and half-boundary positions would expose a reversed walk or swapped halves, which would move the set bit into the wrong response bit. An off-by-one group length would smear a group boundary bit into its neighbour. A design that never cleared an unreached bit would show a stale 1 there. A start injected mid-walk would restart the walk in a design that did not ignore it, which would shift the completion pulse and corrupt the response. The bench also changes the vector after completion, and a design that did not hold its result would show a changed response.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

   function automatic int pair_total(input int k);
      return (k * (k - 1)) / 2;
   endfunction

   function automatic int group_len(input int k, input int m);
      return ((k * (k - 1)) + m - 1) / m;
   endfunction

   // Position of pair (a,b), a<b, within one half of the outcome vector.
   function automatic int pair_offset(input int k, input int a, input int b);
      int off;
      off = 0;
      for (int x = 0; x < k; x++) begin
         if (x < a) off += k - 1 - x;
      end
      return off + (b - a - 1);
   endfunction

endpackage

// File: rtl/pxc_pair_walker.sv
module pxc_pair_walker #(
   parameter int K    = 5,
   parameter int CW   = (K > 2) ? $clog2(K) : 1,
   parameter int IDXW = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic            step_i,
   output logic [IDXW-1:0] idx_o,
   output logic            last_o
);
   import pxc_pkg::*;

   localparam int P = pair_total(K);
   localparam logic [CW-1:0] LAST_CH = CW'(K - 1);
   localparam logic [CW-1:0] LAST_A  = CW'(K - 2);

   logic [CW-1:0] a_q, b_q;
   logic          half_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q    <= '0;
         b_q    <= CW'(1);
         half_q <= 1'b0;
      end else if (load_i) begin
         a_q    <= '0;
         b_q    <= CW'(1);
         half_q <= 1'b0;
      end else if (step_i && !last_o) begin
         if (b_q == LAST_CH) begin
            if (a_q == LAST_A) begin
               half_q <= 1'b1;
               a_q    <= '0;
               b_q    <= CW'(1);
            end else begin
               a_q <= a_q + 1'b1;
               b_q <= a_q + CW'(2);
            end
         end else begin
            b_q <= b_q + 1'b1;
         end
      end
   end

   always_comb begin
      idx_o = IDXW'(pair_offset(K, int'(a_q), int'(b_q)));
      if (half_q) idx_o = idx_o + IDXW'(P);
   end

   assign last_o = half_q && (a_q == LAST_A) && (b_q == LAST_CH);

   // R3: the inner chain index always lies above the outer one
   assert_pair_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_q > a_q);

   // R3: each fold step advances the walk by exactly one outcome position
   assert_walk_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i && !last_o) |=> (idx_o == IDXW'($past(idx_o) + 1'b1)));

endmodule

// File: rtl/pxc_group_fold.sv
module pxc_group_fold #(
   parameter int M     = 4,
   parameter int GROUP = 5,
   parameter int GW    = (GROUP > 1) ? $clog2(GROUP) : 1,
   parameter int BW    = $clog2(M + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         step_i,
   input  logic         bit_i,
   input  logic         last_i,
   output logic [M-1:0] resp_o
);
   logic          acc_q;
   logic [GW-1:0] fill_q;
   logic [BW-1:0] bidx_q;
   logic [M-1:0]  resp_q, resp_d;
   logic          acc_nx;
   logic          close_grp;

   assign acc_nx    = acc_q ^ bit_i;
   assign close_grp = step_i && ((fill_q == GW'(GROUP - 1)) || last_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= 1'b0;
         fill_q <= '0;
         bidx_q <= '0;
      end else if (clear_i) begin
         acc_q  <= 1'b0;
         fill_q <= '0;
         bidx_q <= '0;
      end else if (close_grp) begin
         acc_q  <= 1'b0;
         fill_q <= '0;
         bidx_q <= bidx_q + 1'b1;
      end else if (step_i) begin
         acc_q  <= acc_nx;
         fill_q <= fill_q + 1'b1;
      end
   end

   // One write lane per response bit; a bit is written only when its group closes.
   for (genvar r = 0; r < M; r++) begin : g_lane
      always_comb begin
         if (clear_i)                               resp_d[r] = 1'b0;
         else if (close_grp && bidx_q == BW'(r))    resp_d[r] = acc_nx;
         else                                       resp_d[r] = resp_q[r];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) resp_q <= '0;
      else         resp_q <= resp_d;
   end

   assign resp_o = resp_q;

   // R4: a group never holds more than GROUP outcomes
   assert_group_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_q < GW'(GROUP));

   // R5: the response bit pointer never runs past the top response bit
   assert_bit_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      close_grp |-> (bidx_q < BW'(M)));

endmodule

// File: rtl/pairwise_xor_compressor.sv
module pairwise_xor_compressor #(
   parameter int K = 5,
   parameter int M = 4,
   parameter int NDEC = K * (K - 1)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic [NDEC-1:0] pair_dec_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [M-1:0]    resp_o
);
   import pxc_pkg::*;

   localparam int GROUP = group_len(K, M);
   localparam int IDXW  = (NDEC > 1) ? $clog2(NDEC) : 1;

   if (K < 2) begin : g_bad_k
      $error("pairwise_xor_compressor: K must be at least 2");
   end
   if (M < 1 || M > NDEC) begin : g_bad_m
      $error("pairwise_xor_compressor: M must lie in 1..K(K-1)");
   end
   if (NDEC != K * (K - 1)) begin : g_bad_n
      $error("pairwise_xor_compressor: NDEC must equal K(K-1)");
   end

   logic [NDEC-1:0] dec_q;
   logic            busy_q, done_q;
   logic            accept;
   logic [IDXW-1:0] walk_idx;
   logic            walk_last;

   assign accept = start_i && !busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dec_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            dec_q  <= pair_dec_i;
            busy_q <= 1'b1;
         end else if (busy_q && walk_last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   pxc_pair_walker #(.K(K), .IDXW(IDXW)) u_walk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .step_i (busy_q),
      .idx_o  (walk_idx),
      .last_o (walk_last)
   );

   pxc_group_fold #(.M(M), .GROUP(GROUP)) u_fold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (accept),
      .step_i  (busy_q),
      .bit_i   (dec_q[walk_idx]),
      .last_i  (walk_last),
      .resp_o  (resp_o)
   );

   assign busy_o = busy_q;
   assign done_o = done_q;

   // R6: completion is a single-cycle pulse
   assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   // R9: completion only follows a busy cycle, and busy is low with it
   assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q) |-> ($past(busy_q) && !busy_q));

   // R7: with no walk and no start, the response holds
   assert_resp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && !start_i) |=> $stable(resp_o));

   // R8: a start during a walk neither stops nor rewinds it
   assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && start_i && !walk_last) |=> (busy_q && walk_idx == IDXW'($past(walk_idx) + 1'b1)));

endmodule

// File: tb/test_pairwise_xor_compressor.sv
`timescale 1ns/1ps
module test_pairwise_xor_compressor;

   localparam int NA = 20, MA = 4;
   localparam int NB = 20, MB = 3;
   localparam int NC = 12, MC = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [19:0] vec = '0;

   logic busy_a, done_a, busy_b, done_b, busy_c, done_c;
   logic [MA-1:0] resp_a;
   logic [MB-1:0] resp_b;
   logic [MC-1:0] resp_c;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   pairwise_xor_compressor #(.K(5), .M(MA)) i_pairwise_xor_compressor (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pair_dec_i(vec),
      .busy_o(busy_a), .done_o(done_a), .resp_o(resp_a));

   pairwise_xor_compressor #(.K(5), .M(MB)) i_pairwise_xor_compressor_short (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pair_dec_i(vec),
      .busy_o(busy_b), .done_o(done_b), .resp_o(resp_b));

   pairwise_xor_compressor #(.K(4), .M(MC)) i_pairwise_xor_compressor_wide (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pair_dec_i(vec[NC-1:0]),
      .busy_o(busy_c), .done_o(done_c), .resp_o(resp_c));

   function automatic logic [7:0] fold(input logic [19:0] v, input int n, input int m);
      logic [7:0] r;
      int g;
      r = '0;
      g = (n + m - 1) / m;
      for (int d = 0; d < n; d++) r[d / g] = r[d / g] ^ v[d];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one fold; optionally pulses start again mid-walk with another vector.
   task automatic run(input logic [19:0] v, input bit inject);
      int c;
      int da, db, dc, na, nb, nc;
      logic [19:0] orig;
      orig = v; da = -1; db = -1; dc = -1; na = 0; nb = 0; nc = 0;
      @(negedge clk);
      vec = v; start = 1'b1;
      c = 0;
      while (c < 30) begin
         @(posedge clk); c++;
         @(negedge clk);
         start = 1'b0;
         if (inject && c == 5) begin vec = ~orig; start = 1'b1; end
         if (c == 1) begin
            chk(busy_a && busy_c, "R2 busy after accept", {busy_a, busy_c}, 3);
            chk(resp_a == 0 && resp_b == 0 && resp_c == 0, "R2 response cleared",
                resp_a, 0);
         end
         if (c == 10) chk(busy_a && busy_b, "R9 busy mid-walk", {busy_a, busy_b}, 3);
         if (done_a) begin na++; if (da < 0) da = c; end
         if (done_b) begin nb++; if (db < 0) db = c; end
         if (done_c) begin nc++; if (dc < 0) dc = c; end
         if (done_a) chk(!busy_a, "R9 busy low with done", busy_a, 0);
      end
      chk(da == NA + 1, inject ? "R8 completion time unchanged" : "R6 latency A", da, NA + 1);
      chk(db == NB + 1, "R6 latency B", db, NB + 1);
      chk(dc == NC + 1, "R6 latency C", dc, NC + 1);
      chk(na == 1 && nb == 1 && nc == 1, "R6 single pulse", na * 100 + nb * 10 + nc, 111);
      chk(resp_a == fold(orig, NA, MA)[MA-1:0], inject ? "R8 response from first vector" :
          "R3 R4 exact groups", resp_a, fold(orig, NA, MA));
      chk(resp_b == fold(orig, NB, MB)[MB-1:0], "R5 short last group", resp_b,
          fold(orig, NB, MB));
      chk(resp_c == fold(orig, NC, MC)[MC-1:0], "R5 unreached bit zero", resp_c,
          fold(orig, NC, MC));
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(resp_a == 0 && resp_b == 0 && resp_c == 0, "R1 reset response", resp_a, 0);
      chk(!busy_a && !done_a && !busy_c && !done_c, "R1 reset flags", {busy_a, done_a}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run(20'h00000, 1'b0);
      run(20'hFFFFF, 1'b0);                 // R4 all ones: parity of group lengths
      run(20'h00001, 1'b0);                 // R3 first upper pair lands in bit 0
      run(20'h80000, 1'b0);                 // R3 last lower pair lands in top group
      run(20'h00400, 1'b0);                 // R3 first lower pair (bit 10)
      run(20'h00200, 1'b0);                 // R3 last upper pair (bit 9)
      run(20'h00010, 1'b0);                 // R4 group boundary at bit 4
      run(20'h00020, 1'b0);                 // R4 group boundary at bit 5
      for (int t = 0; t < 24; t++) run(20'($urandom()), 1'b0);
      run(20'h3A5C6, 1'b1);                 // R8 start during walk

      held = {resp_c, resp_a};
      @(negedge clk); vec = ~vec;
      repeat (5) @(negedge clk);
      chk({resp_c, resp_a} == held, "R7 response holds", {resp_c, resp_a}, held);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule